// File: doc/BRIEF.md
# Image Preprocessing Vector Operation Unit

This block executes six element-wise operations used when cleaning up pixel data ahead of a neural network: threshold-to-white, threshold-to-black, conditional negate, binary mask, scalar gain, and scalar gain with accumulate. Each request supplies an opcode, a source vector, the old destination vector, one 8-bit scalar that is broadcast to every element, and an active element count. The vectors are `VLEN` bits long and hold 8-bit elements. The scalar multiplies are fixed-point: the 16-bit product is shifted right by 8.

The unit works through the vector one datapath-wide chunk per cycle. The chunk width `DPW` is a parameter, so one request takes `ceil(VLEN/DPW)` cycles. While the unit works, `busy` is high. When the last chunk has been written, `done` pulses for one cycle and the complete result is on `result`. Elements at or beyond the active count keep their old destination value, so a short vector merges into the old contents.

Top module: `vimg_unit`

## Requirements
- R1: Opcode 0 (threshold-to-white) writes 255 where vs1 > rs2 (unsigned) and vs1 otherwise.
- R2: Opcode 1 (threshold-to-black) writes vs1 where vs1 > rs2 (unsigned) and 0 otherwise.
- R3: Opcode 2 (conditional negate) writes vs1 where vs1 > rs2 as signed 8-bit values, and the 8-bit two's-complement negation of vs1 otherwise.
- R4: Opcode 3 (mask) writes 255 where vs1 > rs2 (unsigned) and 0 otherwise.
- R5: Opcode 4 (gain) writes bits 15:8 of the unsigned 16-bit product vs1*rs2.
- R6: Opcode 5 (gain-accumulate) writes old vd plus bits 15:8 of vs1*rs2, truncated to 8 bits.
- R7: Element k sits in bits [8k+7:8k]. Elements with index >= the active count keep the old vd value.
- R8: Opcodes 6 and 7 leave every element at its old vd value and still produce a done pulse.
- R9: A start taken while idle holds busy high for exactly ceil(VLEN/DPW) cycles. Then done is high for one cycle, with busy low.
- R10: A start that arrives while busy is ignored and does not change the running request's result.
- R11: While idle and without a start, result holds its value. After reset, result is 0 and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| opcode | input | 3 | Operation select |
| vs1 | input | VLEN | Source vector |
| vdOld | input | VLEN | Old destination vector |
| rs2 | input | 8 | Broadcast scalar |
| vl | input | clog2(VLEN/8+1) | Active element count |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | VLEN | Result vector |

## Verification
The bound checker watches the sequencing on every cycle. It checks that an idle start raises busy, that busy lasts exactly the chunk count before done, that done is a single cycle and never overlaps busy, and that the result is frozen while idle. The per-element arithmetic cannot be checked that way. The bench scenarios cover it: the signed and unsigned compare edges (equal values, 0x7F against 0x80), truncation of products and sums, the partial active count, unknown opcodes, and a start injected mid-run.

// File: rtl/vimg_pkg.sv
package vimg_pkg;
  localparam int EW = 8;

  typedef enum logic [2:0] {
    OP_WHITE = 3'd0,
    OP_BLACK = 3'd1,
    OP_NEG   = 3'd2,
    OP_MASK  = 3'd3,
    OP_GAIN  = 3'd4,
    OP_GACC  = 3'd5
  } vimgOp_e;

  typedef struct packed {
    logic load;   // capture a new request
    logic step;   // process the current chunk
  } vimgCtrl_t;

  function automatic logic [EW-1:0] laneCalc(input logic [2:0] op, input logic [EW-1:0] a,
                                             input logic [EW-1:0] s, input logic [EW-1:0] old);
    logic [2*EW-1:0] prod;
    logic gtU, gtS;
    prod = a * s;
    gtU  = a > s;
    gtS  = $signed(a) > $signed(s);
    case (op)
      OP_WHITE: laneCalc = gtU ? 8'd255 : a;
      OP_BLACK: laneCalc = gtU ? a : 8'd0;
      OP_NEG:   laneCalc = gtS ? a : (~a + 8'd1);
      OP_MASK:  laneCalc = gtU ? 8'd255 : 8'd0;
      OP_GAIN:  laneCalc = prod[2*EW-1:EW];
      OP_GACC:  laneCalc = old + prod[2*EW-1:EW];
      default:  laneCalc = old;
    endcase
  endfunction
endpackage

// File: rtl/vimg_ctrl.sv
module vimg_ctrl
  import vimg_pkg::*;
#(
  parameter int NCHUNK = 4,
  localparam int CW = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output vimgCtrl_t     ctrl,
  output logic [CW-1:0] chunkIdx
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        if (cnt == CW'(NCHUNK - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    ctrl.load = !busy && start;
    ctrl.step = busy;
  end
  assign chunkIdx = cnt;
endmodule

// File: rtl/vimg_datapath.sv
module vimg_datapath
  import vimg_pkg::*;
#(
  parameter int VLEN   = 256,
  parameter int DPW    = 64,
  parameter int NCHUNK = 4,
  localparam int NE    = VLEN / EW,
  localparam int LANES = DPW / EW,
  localparam int PADW  = NCHUNK * DPW,
  localparam int VLW   = $clog2(NE + 1),
  localparam int CW    = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  vimgCtrl_t       ctrl,
  input  logic [CW-1:0]   chunkIdx,
  input  logic [2:0]      opcode,
  input  logic [VLEN-1:0] vs1,
  input  logic [VLEN-1:0] vdOld,
  input  logic [EW-1:0]   rs2,
  input  logic [VLW-1:0]  vl,
  output logic [VLEN-1:0] result
);
  logic [2:0]      opReg;
  logic [EW-1:0]   rs2Reg;
  logic [VLW-1:0]  vlReg;
  logic [PADW-1:0] srcPad;
  logic [PADW-1:0] resPad;
  logic [EW-1:0]   laneOut [LANES];
  logic [LANES-1:0] laneOn;
  logic            opOk;

  assign opOk = (opReg <= 3'd5);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [EW-1:0] srcEl, oldEl;
    assign srcEl      = srcPad[int'(chunkIdx) * DPW + i * EW +: EW];
    assign oldEl      = resPad[int'(chunkIdx) * DPW + i * EW +: EW];
    assign laneOut[i] = laneCalc(opReg, srcEl, rs2Reg, oldEl);
    assign laneOn[i]  = opOk && ((int'(chunkIdx) * LANES + i) < int'(vlReg));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg  <= '0;
      rs2Reg <= '0;
      vlReg  <= '0;
      srcPad <= '0;
      resPad <= '0;
    end else if (ctrl.load) begin
      opReg  <= opcode;
      rs2Reg <= rs2;
      vlReg  <= vl;
      srcPad <= PADW'(vs1);
      resPad <= PADW'(vdOld);
    end else if (ctrl.step) begin
      for (int i = 0; i < LANES; i++) begin
        if (laneOn[i]) resPad[int'(chunkIdx) * DPW + i * EW +: EW] <= laneOut[i];
      end
    end
  end

  assign result = resPad[VLEN-1:0];
endmodule

// File: rtl/vimg_unit.sv
module vimg_unit
  import vimg_pkg::*;
#(
  parameter int VLEN = 256,
  parameter int DPW  = 64,
  localparam int NCHUNK = (VLEN + DPW - 1) / DPW,
  localparam int CW     = (NCHUNK > 1) ? $clog2(NCHUNK) : 1,
  localparam int VLW    = $clog2(VLEN / 8 + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [2:0]      opcode,
  input  logic [VLEN-1:0] vs1,
  input  logic [VLEN-1:0] vdOld,
  input  logic [7:0]      rs2,
  input  logic [VLW-1:0]  vl,
  output logic            busy,
  output logic            done,
  output logic [VLEN-1:0] result
);
  vimgCtrl_t     ctrl;
  logic [CW-1:0] chunkIdx;

  vimg_ctrl #(.NCHUNK(NCHUNK)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .ctrl(ctrl), .chunkIdx(chunkIdx)
  );

  vimg_datapath #(.VLEN(VLEN), .DPW(DPW), .NCHUNK(NCHUNK)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .chunkIdx(chunkIdx), .opcode(opcode),
    .vs1(vs1), .vdOld(vdOld), .rs2(rs2), .vl(vl), .result(result)
  );
endmodule

// File: rtl/vimg_chk.sv
module vimg_chk #(
  parameter int VLEN = 256,
  parameter int DPW  = 64,
  localparam int NCHUNK = (VLEN + DPW - 1) / DPW
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [VLEN-1:0] result
);
  int busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN)              busyCnt <= 0;
    else if (start && !busy) busyCnt <= 0;
    else if (busy)          busyCnt <= busyCnt + 1;
  end

  a_r9_start_raises_busy: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  a_r9_done_after_full_run: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCnt == NCHUNK));
  a_r9_busy_bounded: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyCnt < NCHUNK));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(result));
endmodule

bind vimg_unit vimg_chk #(.VLEN(VLEN), .DPW(DPW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done), .result(result)
);

// File: tb/vimg_unit_tb.sv
module vimg_unit_tb;
  localparam int VLEN = 256;
  localparam int DPW  = 64;
  localparam int NE   = VLEN / 8;
  localparam int NC   = (VLEN + DPW - 1) / DPW;
  localparam int VLW  = $clog2(NE + 1);

  logic clk = 0, rstN = 0, start = 0;
  logic [2:0] opcode = 0;
  logic [VLEN-1:0] vs1 = 0, vdOld = 0, result;
  logic [7:0] rs2 = 0;
  logic [VLW-1:0] vl = 0;
  logic busy, done;

  int checks = 0, errors = 0;
  logic [VLEN-1:0] expQ[$];
  string tagQ[$];
  logic [VLEN-1:0] lastRes;

  always #5 clk = ~clk;

  vimg_unit #(.VLEN(VLEN), .DPW(DPW)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .vs1(vs1), .vdOld(vdOld),
    .rs2(rs2), .vl(vl), .busy(busy), .done(done), .result(result)
  );

  function automatic logic [7:0] elemRef(input int op, input logic [7:0] a, input logic [7:0] s,
                                         input logic [7:0] old);
    logic [15:0] p;
    p = {8'd0, a} * {8'd0, s};
    case (op)
      0: return (a > s) ? 8'd255 : a;                        // R1
      1: return (a > s) ? a : 8'd0;                          // R2
      2: return ($signed(a) > $signed(s)) ? a : 8'(0 - a);   // R3
      3: return (a > s) ? 8'd255 : 8'd0;                     // R4
      4: return p[15:8];                                     // R5
      5: return 8'(old + p[15:8]);                           // R6
      default: return old;                                   // R8
    endcase
  endfunction

  function automatic logic [VLEN-1:0] vecRef(input int op, input logic [VLEN-1:0] a,
                                             input logic [VLEN-1:0] d, input logic [7:0] s, input int n);
    logic [VLEN-1:0] r;
    r = d;
    for (int k = 0; k < NE; k++)
      if (k < n) r[8*k +: 8] = elemRef(op, a[8*k +: 8], s, d[8*k +: 8]);  // R7
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations on done
  always @(negedge clk) begin
    if (done) begin
      if (expQ.size() == 0) check(0, "R9 unexpected done", 0, 0);
      else begin
        logic [VLEN-1:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(result === e, t, result, e);
        lastRes = result;
      end
    end
  end

  // driver: pushes expectation, pulses start, optionally injects a start while busy
  task automatic runOp(input int op, input logic [VLEN-1:0] a, input logic [VLEN-1:0] d,
                       input logic [7:0] s, input int n, input string tag, input bit inject = 0);
    int cyc;
    expQ.push_back(vecRef(op, a, d, s, n));
    tagQ.push_back(tag);
    @(negedge clk);
    opcode = 3'(op); vs1 = a; vdOld = d; rs2 = s; vl = VLW'(n); start = 1;
    @(negedge clk);
    start = 0;
    cyc = 0;
    if (inject) begin   // R10: different request while busy
      opcode = 3'd3; vs1 = ~a; vdOld = ~d; rs2 = 8'd1; vl = VLW'(NE); start = 1;
    end
    while (!done) begin
      if (busy) cyc++;
      @(negedge clk);
      start = 0;
    end
    check(cyc == NC, "R9 busy cycle count", VLEN'(cyc), VLEN'(NC));
    @(negedge clk);
    check(!busy && !done, "R9 done lasts one cycle", VLEN'({busy, done}), 0);
  endtask

  function automatic logic [VLEN-1:0] rndVec();
    logic [VLEN-1:0] v;
    for (int k = 0; k < VLEN / 32; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    logic [VLEN-1:0] ramp, a, d;
    for (int k = 0; k < NE; k++) ramp[8*k +: 8] = 8'(k * 8 + 3);
    repeat (3) @(negedge clk);
    check(!busy && !done && result == 0, "R11 reset state", result, 0);
    rstN = 1;

    // corner pattern: equal, 0x7F/0x80 edges included via rs2 choice
    a = ramp; a[7:0] = 8'h80; a[15:8] = 8'h7F; a[23:16] = 8'h00; a[31:24] = 8'hFF;
    d = rndVec();
    runOp(0, a, d, 8'h7F, NE, "R1 white, equal/edge");
    runOp(1, a, d, 8'h7F, NE, "R2 black, equal/edge");
    runOp(2, a, d, 8'h7F, NE, "R3 negate, signed edge 7F");
    runOp(2, a, d, 8'h80, NE, "R3 negate, signed min");
    runOp(3, a, d, 8'h7F, NE, "R4 mask");
    runOp(4, a, d, 8'hFF, NE, "R5 gain max");
    runOp(5, a, ~0, 8'hFF, NE, "R6 accumulate wraps");
    for (int t = 0; t < 6; t++) begin
      a = rndVec(); d = rndVec();
      runOp(t, a, d, 8'($urandom), NE, $sformatf("R%0d random full", t + 1));
    end
    runOp(0, rndVec(), rndVec(), 8'h40, 13, "R7 partial count 13");
    runOp(5, rndVec(), rndVec(), 8'h90, 0, "R7 zero count");
    runOp(4, rndVec(), rndVec(), 8'h33, 8, "R7 chunk boundary count");
    runOp(6, rndVec(), rndVec(), 8'h10, NE, "R8 unknown opcode 6");
    runOp(7, rndVec(), rndVec(), 8'h10, NE, "R8 unknown opcode 7");
    runOp(2, rndVec(), rndVec(), 8'h05, NE, "R10 start while busy ignored", 1);

    // R11: idle, inputs wiggle, no start
    vs1 = rndVec(); vdOld = rndVec(); opcode = 3'd3;
    repeat (4) @(negedge clk);
    check(result === lastRes && !busy && !done, "R11 idle hold", result, lastRes);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    check(0, "watchdog", 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule